// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command interpreter on the device side of a byte-wide 512 K x 8 parallel NOR flash. It watches byte write cycles, each a 19-bit address with an 8-bit data value, and recognises the multi-cycle unlock-and-command sequences. When a sequence completes, it sends a single-cycle pulse to a storage back end. The pulse is one of three: program (carrying the target address and data byte), whole-chip erase, or erase of one 64 KB sector (carrying the sector number).

The block also has an identification mode. In that mode, reads return a manufacturer code and a device code, both set by parameters, in place of array contents. Outside that mode, a read is a single cycle. The address goes out and the data coming back on the array read port is passed through unchanged in the same cycle. The back end reports work in progress on a busy input. A global write-enable input gates every write cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: Outside identification mode, `rdData` equals `arrayData` in the same cycle, combinationally, for any address.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then any data at any address raise `pgmPulse` for exactly the one cycle after the fourth write's clock edge. In that cycle `pgmAddr` and `pgmData` hold that fourth write's address and data. The fourth write is always taken as data, even when its value is 0xF0.
- R3: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 raise `chipErasePulse` for the one cycle after the sixth write's edge.
- R4: The same five-write prefix followed by 0x30 written to any address raises `sectorErasePulse` for one cycle. `sectorNum` equals bits 18:16 of that sixth write's address. A 0x10 sixth write at 0x555 selects chip erase, not sector erase.
- R5: Unlock and command steps compare only address bits 10:0 against 0x555 and 0x2AA. Bits 18:11 are ignored.
- R6: A write whose address or data does not match the expected next step returns the sequencer to read mode and issues no pulse. A following command write on its own does nothing; the full sequence must start again.
- R7: The writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 enter identification mode. In this mode a read at address 0 returns `MFR_ID`, a read at address 1 returns `DEV_ID`, and any other address returns 0x00. Writes other than 0xF0 are ignored in this mode.
- R8: A write of 0xF0, at any address and outside the program-data step, returns the block to array-read mode. This includes leaving identification mode.
- R9: While `writeEnable` is low, write cycles are ignored. The position in the sequence is kept, so a sequence can continue once `writeEnable` is high again.
- R10: While `beBusy` is high, write cycles issue no command. The sequencer is forced to read mode, which drops any partial sequence and leaves identification mode.
- R11: After reset all pulses are low. At most one of the three pulses is high in any cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| writeEnable | input | 1 | Global gate for write cycles |
| wrValid | input | 1 | A write cycle is present this clock |
| addr | input | 19 | Byte address for writes and reads |
| wrData | input | 8 | Write data byte |
| arrayData | input | 8 | Read data from the storage array at `addr` |
| beBusy | input | 1 | Back end is executing a command |
| rdData | output | 8 | Read data returned to the bus |
| pgmPulse | output | 1 | Program one byte |
| pgmAddr | output | 19 | Address to program |
| pgmData | output | 8 | Byte to program |
| chipErasePulse | output | 1 | Erase the whole array |
| sectorErasePulse | output | 1 | Erase one sector |
| sectorNum | output | 3 | Sector to erase |

## Verification
The bench targets the places where erase sequences branch and where they break.

- A shared six-cycle prefix ends in 0x10 at 0x555, in 0x30 at 0x555, or in 0x30 at a far address. A design that decoded the last cycle in the wrong order would issue a sector erase instead of a chip erase, or the reverse.
- Unlock writes are sent with nonzero upper address bits. A design that compared the full address would then silently refuse commands.
- Aborted sequences are followed by a lone command byte. A design that did not reset on a mismatch would program spuriously.
- A 0xF0 is written as program data. A design that gave the reset code priority there would drop the program.
- Write-enable gaps are placed mid-sequence, and busy is raised both in identification mode and mid-sequence. These catch designs that lose their position or keep stale state.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  // Sequencer positions; names describe how far a sequence has progressed.
  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ERA1,
    ST_ERA2,
    ST_ERA3,
    ST_IDENT
  } seqState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadPgm;
    logic fireChip;
    logic fireSector;
    logic setIdent;
    logic clrIdent;
  } seqStrobe_t;

  localparam logic [10:0] OFS_FIRST  = 11'h555;
  localparam logic [10:0] OFS_SECOND = 11'h2AA;

  localparam logic [7:0] CODE_UNLA   = 8'hAA;
  localparam logic [7:0] CODE_UNLB   = 8'h55;
  localparam logic [7:0] CODE_PGM    = 8'hA0;
  localparam logic [7:0] CODE_IDENT  = 8'h90;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
  localparam logic [7:0] CODE_RESET  = 8'hF0;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeEnable,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              beBusy,
  output seqStrobe_t        strobe
);

  seqState_t state, nxt;

  logic             accept;
  logic [CMP_W-1:0] offs;
  logic             atFirst, atSecond, isUnlA, isUnlB;

  assign accept   = wrValid && writeEnable && !beBusy;
  assign offs     = addr[CMP_W-1:0];
  assign atFirst  = (offs == CMP_W'(OFS_FIRST));
  assign atSecond = (offs == CMP_W'(OFS_SECOND));
  assign isUnlA   = atFirst  && (wrData == DATA_W'(CODE_UNLA));
  assign isUnlB   = atSecond && (wrData == DATA_W'(CODE_UNLB));

  always_comb begin
    nxt    = state;
    strobe = '0;
    if (beBusy) begin
      nxt = ST_READ;
    end else if (accept) begin
      case (state)
        ST_READ: if (isUnlA) nxt = ST_UNL1;
        ST_UNL1: nxt = isUnlB ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (atFirst && wrData == DATA_W'(CODE_PGM))        nxt = ST_PGM;
          else if (atFirst && wrData == DATA_W'(CODE_IDENT)) begin
            nxt             = ST_IDENT;
            strobe.setIdent = 1'b1;
          end
          else if (atFirst && wrData == DATA_W'(CODE_ERASE)) nxt = ST_ERA1;
          else                                               nxt = ST_READ;
        end
        ST_PGM: begin
          strobe.loadPgm = 1'b1;
          nxt            = ST_READ;
        end
        ST_ERA1: nxt = isUnlA ? ST_ERA2 : ST_READ;
        ST_ERA2: nxt = isUnlB ? ST_ERA3 : ST_READ;
        ST_ERA3: begin
          if (atFirst && wrData == DATA_W'(CODE_CHIP))  strobe.fireChip   = 1'b1;
          else if (wrData == DATA_W'(CODE_SECTOR))      strobe.fireSector = 1'b1;
          nxt = ST_READ;
        end
        ST_IDENT: if (wrData == DATA_W'(CODE_RESET)) nxt = ST_READ;
        default:  nxt = ST_READ;
      endcase
    end
    if (state == ST_IDENT && nxt != ST_IDENT) strobe.clrIdent = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_READ;
    else       state <= nxt;
  end

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int                ADDR_W = 19,
  parameter int                DATA_W = 8,
  parameter int                SECT_W = 3,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 8'hA4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              pgmPulse,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [DATA_W-1:0] pgmData,
  output logic              chipErasePulse,
  output logic              sectorErasePulse,
  output logic [SECT_W-1:0] sectorNum
);

  logic identQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      identQ           <= 1'b0;
      pgmPulse         <= 1'b0;
      chipErasePulse   <= 1'b0;
      sectorErasePulse <= 1'b0;
      pgmAddr          <= '0;
      pgmData          <= '0;
      sectorNum        <= '0;
    end else begin
      pgmPulse         <= strobe.loadPgm;
      chipErasePulse   <= strobe.fireChip;
      sectorErasePulse <= strobe.fireSector;
      if (strobe.setIdent)      identQ <= 1'b1;
      else if (strobe.clrIdent) identQ <= 1'b0;
      if (strobe.loadPgm) begin
        pgmAddr <= addr;
        pgmData <= wrData;
      end
      if (strobe.fireSector) sectorNum <= addr[ADDR_W-1 -: SECT_W];
    end
  end

  always_comb begin
    if (!identQ)                        rdData = arrayData;
    else if (addr == ADDR_W'(0))        rdData = MFR_ID;
    else if (addr == ADDR_W'(1))        rdData = DEV_ID;
    else                                rdData = '0;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int                ADDR_W = 19,
  parameter int                DATA_W = 8,
  parameter int                CMP_W  = 11,
  parameter int                SECT_W = 3,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 8'hA4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeEnable,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              beBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              pgmPulse,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [DATA_W-1:0] pgmData,
  output logic              chipErasePulse,
  output logic              sectorErasePulse,
  output logic [SECT_W-1:0] sectorNum
);

  seqStrobe_t strobe;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .writeEnable(writeEnable), .wrValid(wrValid),
    .addr(addr), .wrData(wrData), .beBusy(beBusy), .strobe(strobe)
  );

  flash_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .arrayData(arrayData), .rdData(rdData), .pgmPulse(pgmPulse),
    .pgmAddr(pgmAddr), .pgmData(pgmData), .chipErasePulse(chipErasePulse),
    .sectorErasePulse(sectorErasePulse), .sectorNum(sectorNum)
  );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              writeEnable,
  input logic              wrValid,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              beBusy,
  input logic              pgmPulse,
  input logic [ADDR_W-1:0] pgmAddr,
  input logic [DATA_W-1:0] pgmData,
  input logic              chipErasePulse,
  input logic              sectorErasePulse,
  input logic [SECT_W-1:0] sectorNum
);

  // R11: commands are mutually exclusive
  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pgmPulse, chipErasePulse, sectorErasePulse}));

  // R11: pulses last one cycle
  p_pgm_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    pgmPulse |=> !pgmPulse);

  // R2: program carries the last write
  p_pgm_payload_r2: assert property (@(posedge clk) disable iff (!rstN)
    pgmPulse |-> (pgmAddr == $past(addr) && pgmData == $past(wrData) && $past(wrValid)));

  // R3: chip erase follows a 0x10 write
  p_chip_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    chipErasePulse |-> ($past(wrValid) && $past(wrData) == 8'h10));

  // R4: sector number is the top address bits of the final write
  p_sector_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    sectorErasePulse |-> (sectorNum == $past(addr[ADDR_W-1 -: SECT_W]) && $past(wrData) == 8'h30));

  // R9: gated writes issue nothing
  p_we_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !writeEnable |=> !(pgmPulse || chipErasePulse || sectorErasePulse));

  // R10: writes during busy issue nothing
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    beBusy |=> !(pgmPulse || chipErasePulse || sectorErasePulse));

endmodule

bind flash_cmd_seq flash_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .writeEnable(writeEnable), .wrValid(wrValid),
  .addr(addr), .wrData(wrData), .beBusy(beBusy), .pgmPulse(pgmPulse),
  .pgmAddr(pgmAddr), .pgmData(pgmData), .chipErasePulse(chipErasePulse),
  .sectorErasePulse(sectorErasePulse), .sectorNum(sectorNum)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;

  localparam logic [7:0] MFR = 8'h01;
  localparam logic [7:0] DEV = 8'hA4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        writeEnable = 1'b1;
  logic        wrValid = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  arrayData = '0;
  logic        beBusy = 1'b0;
  logic [7:0]  rdData;
  logic        pgmPulse, chipErasePulse, sectorErasePulse;
  logic [18:0] pgmAddr;
  logic [7:0]  pgmData;
  logic [2:0]  sectorNum;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.MFR_ID(MFR), .DEV_ID(DEV)) dut (
    .clk(clk), .rstN(rstN), .writeEnable(writeEnable), .wrValid(wrValid),
    .addr(addr), .wrData(wrData), .arrayData(arrayData), .beBusy(beBusy),
    .rdData(rdData), .pgmPulse(pgmPulse), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .chipErasePulse(chipErasePulse), .sectorErasePulse(sectorErasePulse),
    .sectorNum(sectorNum)
  );

  // ---------------- behavioural reference model ----------------
  int          step = 0;     // matched cycles; 10 means awaiting program data
  bit          inId = 0;
  bit          eP = 0, eC = 0, eS = 0;
  logic [18:0] ePA = '0;
  logic [7:0]  ePD = '0;
  logic [2:0]  eSec = '0;
  int          nP = 0, nC = 0, nS = 0;  // expected command counts

  always @(posedge clk) begin
    int lo;
    eP <= 0; eC <= 0; eS <= 0;
    lo = int'(addr & 19'h7FF);
    if (!rstN) begin
      step = 0; inId = 0;
    end else if (beBusy) begin
      step = 0; inId = 0;
    end else if (wrValid && writeEnable) begin
      if (step == 10) begin
        eP <= 1; ePA <= addr; ePD <= wrData; step = 0; nP++;
      end else if (wrData == 8'hF0) begin
        step = 0; inId = 0;
      end else if (inId) begin
        // ignored
      end else if ((step == 0 || step == 3) && lo == 'h555 && wrData == 8'hAA) step = step + 1;
      else if ((step == 1 || step == 4) && lo == 'h2AA && wrData == 8'h55) step = step + 1;
      else if (step == 2 && lo == 'h555 && wrData == 8'hA0) step = 10;
      else if (step == 2 && lo == 'h555 && wrData == 8'h90) begin step = 0; inId = 1; end
      else if (step == 2 && lo == 'h555 && wrData == 8'h80) step = 3;
      else if (step == 5 && lo == 'h555 && wrData == 8'h10) begin eC <= 1; step = 0; nC++; end
      else if (step == 5 && wrData == 8'h30) begin eS <= 1; eSec <= addr[18:16]; step = 0; nS++; end
      else step = 0;
    end
  end

  function automatic logic [7:0] expRead(logic [18:0] a, logic [7:0] arr);
    if (!inId) return arr;
    if (a == 0) return MFR;
    if (a == 1) return DEV;
    return 8'h00;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at negedge, check read after settle, check pulses at next negedge.
  task automatic cyc(bit v, logic [18:0] a, logic [7:0] d, string req);
    wrValid = v; addr = a; wrData = d; arrayData = a[7:0] ^ 8'h5A;
    #1;
    chk(rdData == expRead(a, arrayData), {req, " R1/R7 rdData"}, rdData, expRead(a, arrayData));
    @(posedge clk);
    @(negedge clk);
    chk(pgmPulse == eP, {req, " R2 pgmPulse"}, pgmPulse, eP);
    chk(chipErasePulse == eC, {req, " R3 chipErasePulse"}, chipErasePulse, eC);
    chk(sectorErasePulse == eS, {req, " R4 sectorErasePulse"}, sectorErasePulse, eS);
    if (eP) begin
      chk(pgmAddr == ePA, {req, " R2 pgmAddr"}, pgmAddr, ePA);
      chk(pgmData == ePD, {req, " R2 pgmData"}, pgmData, ePD);
    end
    if (eS) chk(sectorNum == eSec, {req, " R4 sectorNum"}, sectorNum, eSec);
    chk($countones({pgmPulse, chipErasePulse, sectorErasePulse}) <= 1, "R11 exclusive",
        {pgmPulse, chipErasePulse, sectorErasePulse}, 0);
  endtask

  task automatic wr(logic [18:0] a, logic [7:0] d, string req); cyc(1, a, d, req); endtask
  task automatic rd(logic [18:0] a, string req);               cyc(0, a, 8'h00, req); endtask

  task automatic unlock(logic [18:0] hi, string req);
    wr(hi | 19'h555, 8'hAA, req);
    wr(hi | 19'h2AA, 8'h55, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pgmPulse && !chipErasePulse && !sectorErasePulse, "R11 reset pulses", pgmPulse, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: plain reads pass through
    rd(19'h12345, "R1"); rd(19'h00000, "R1"); rd(19'h00001, "R1");

    // R2: program, then program with 0xF0 data
    unlock(0, "R2"); wr(19'h555, 8'hA0, "R2"); wr(19'h4_3210, 8'h3C, "R2");
    unlock(0, "R2"); wr(19'h555, 8'hA0, "R2"); wr(19'h7_FFFF, 8'hF0, "R2");

    // R3: chip erase
    unlock(0, "R3"); wr(19'h555, 8'h80, "R3"); unlock(0, "R3"); wr(19'h555, 8'h10, "R3");

    // R4: sector erase at far address, and with 0x30 at 0x555
    unlock(0, "R4"); wr(19'h555, 8'h80, "R4"); unlock(0, "R4"); wr(19'h5_1234, 8'h30, "R4");
    unlock(0, "R4"); wr(19'h555, 8'h80, "R4"); unlock(0, "R4"); wr(19'h555, 8'h30, "R4");

    // R5: upper address bits ignored in unlock
    unlock(19'h7_0000, "R5"); wr(19'h3_0555, 8'hA0, "R5"); wr(19'h0_0042, 8'h99, "R5");

    // R6: broken sequence then lone command and data
    unlock(0, "R6"); wr(19'h555, 8'h77, "R6"); wr(19'h555, 8'hA0, "R6"); wr(19'h100, 8'h11, "R6");
    wr(19'h555, 8'hAA, "R6"); wr(19'h2AB, 8'h55, "R6"); wr(19'h555, 8'hA0, "R6"); wr(19'h100, 8'h22, "R6");

    // R7: identification mode reads; other writes ignored
    unlock(0, "R7"); wr(19'h555, 8'h90, "R7");
    rd(19'h0, "R7"); rd(19'h1, "R7"); rd(19'h2, "R7"); rd(19'h4_0000, "R7");
    unlock(0, "R7"); wr(19'h555, 8'hA0, "R7"); wr(19'h200, 8'h12, "R7");
    rd(19'h1, "R7");

    // R8: 0xF0 exits identification mode
    wr(19'h6_0000, 8'hF0, "R8"); rd(19'h0, "R8"); rd(19'h1, "R8");

    // R9: writeEnable low mid-sequence holds position
    unlock(0, "R9");
    writeEnable = 1'b0;
    wr(19'h555, 8'h77, "R9"); wr(19'h555, 8'hA0, "R9");
    writeEnable = 1'b1;
    wr(19'h555, 8'hA0, "R9"); wr(19'h1_2345, 8'h5E, "R9");
    writeEnable = 1'b0;
    unlock(0, "R9"); wr(19'h555, 8'hA0, "R9"); wr(19'h10, 8'h01, "R9");
    writeEnable = 1'b1;

    // R10: busy ignores writes, drops partial sequence and id mode
    unlock(0, "R10"); wr(19'h555, 8'h80, "R10");
    beBusy = 1'b1; rd(19'h0, "R10"); wr(19'h555, 8'hAA, "R10"); beBusy = 1'b0;
    wr(19'h2AA, 8'h55, "R10"); wr(19'h555, 8'h10, "R10");
    unlock(0, "R10"); wr(19'h555, 8'h90, "R10"); rd(19'h0, "R10");
    beBusy = 1'b1; rd(19'h1, "R10"); beBusy = 1'b0;
    rd(19'h0, "R10"); rd(19'h1, "R10");

    chk(nP == 4 && nC == 1 && nS == 2, "R2/R3/R4 model command count", nP * 100 + nC * 10 + nS, 412);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule